// File: doc/BRIEF.md
# Write-Update Coherence Controller

This block is the coherence engine of one private cache on a shared snooping bus. It keeps a small direct-mapped array of four-word lines. Each valid line is in one of four states: Valid-Exclusive, Shared-Clean, Shared-Dirty or Dirty. The controller serves load and store requests from its processor. When a request misses, or when a store hits a line that other caches may also hold, it becomes a bus master. While another cache owns the bus, it answers that cache's transactions.

Coherence is kept by updating copies, not by invalidating them. A store to a shared line sends the written word over the bus, and every other holder patches its own copy. The bus carries a wired-OR "copy present" signal. A snooping cache raises it when it holds the addressed line. The requesting cache samples it when the transaction completes. After a line fill, the sample chooses between the exclusive state and the shared state. After a word broadcast, it chooses between owned-and-shared and owned-alone. Memory is written only when an owned line is evicted. Bus arbitration and completion are reduced to a request signal held until a one-cycle acknowledge.

Top module: `upd_coh_ctrl`

## Requirements
- R1: After reset every line is invalid. `cpu_done`, `bus_req` and `shd_out` are low, and a snooped read of any address gets no copy-present response.
- R2: A load miss issues one fill command (`bus_cmd` = 1) carrying the line address, which is the request address with its two low word-offset bits cleared. The load returns word `addr[1:0]` of `bus_line_in`. Word k of a line occupies bits [16k+15:16k]. The new line becomes Shared-Clean if `shd_in` is high at the acknowledge, otherwise Valid-Exclusive.
- R3: A load that hits returns the cached word and makes no bus request.
- R4: A store that hits a Valid-Exclusive or Dirty line completes with no bus request and leaves the line Dirty.
- R5: A store that hits a Shared-Clean or Shared-Dirty line writes the word locally. It then issues one word-update command (`bus_cmd` = 2) with the word address and data. After that command the line is Shared-Dirty if `shd_in` is high at the acknowledge, otherwise Dirty.
- R6: A store miss fills the line as in R2 and merges the word into it. If the fill saw `shd_in` high, it then broadcasts the word as in R5. Otherwise it ends Dirty with no broadcast.
- R7: A miss whose victim line is Dirty or Shared-Dirty first issues a writeback (`bus_cmd` = 3). The writeback carries the victim's line address and whole line, and the fill follows it. A Valid-Exclusive or Shared-Clean victim is dropped without a writeback.
- R8: While `snp_valid` is high with a fill or word-update command, `shd_out` is high in the same cycle exactly when the addressed line is held. Address bits [3:2] give the set and [7:4] give the tag.
- R9: A snooped fill that hits a Dirty or Shared-Dirty line raises `snp_supply` and presents the line on `snp_line`. A snooped fill that hits a clean line does not raise `snp_supply`. Afterwards Dirty becomes Shared-Dirty and Valid-Exclusive becomes Shared-Clean.
- R10: A snooped word update that hits a held line writes the word into the copy and leaves the line Shared-Clean. A snooped writeback draws no copy-present response.
- R11: The controller drives only fill, word-update and writeback commands, never any invalidation. `bus_cmd` is 0 whenever `bus_req` is low.
- R12: `cpu_done` is a single-cycle pulse for each request, and `cpu_rdata` is valid with it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cpu_req | input | 1 | Processor request, held until `cpu_done` |
| cpu_we | input | 1 | 1 = store, 0 = load |
| cpu_addr | input | ADDR_W | Word address of the request |
| cpu_wdata | input | DATA_W | Store data |
| cpu_done | output | 1 | Request complete (one cycle) |
| cpu_rdata | output | DATA_W | Load result |
| bus_req | output | 1 | Bus transaction pending, held until `bus_ack` |
| bus_cmd | output | 2 | 0 idle, 1 fill, 2 word update, 3 writeback |
| bus_addr | output | ADDR_W | Line address (fill, writeback) or word address (update) |
| bus_wdata | output | DATA_W | Word carried by an update |
| bus_line_out | output | LINE_W | Line carried by a writeback |
| bus_ack | input | 1 | Transaction complete, one cycle |
| bus_line_in | input | LINE_W | Fill data, valid with `bus_ack` |
| shd_in | input | 1 | Wired copy-present signal sampled at `bus_ack` |
| snp_valid | input | 1 | Another cache's transaction is on the bus |
| snp_cmd | input | 2 | Command of that transaction |
| snp_addr | input | ADDR_W | Address of that transaction |
| snp_wdata | input | DATA_W | Word of a snooped update |
| shd_out | output | 1 | This cache holds the snooped line |
| snp_supply | output | 1 | This cache supplies the snooped fill |
| snp_line | output | LINE_W | Line offered for the snooped fill |

## Verification
Every stored state becomes visible at the ports no later than the next event that depends on it. A line wrongly marked exclusive or shared shows up at the very next store hit as a missing or extra word-update command. A wrong owner marking shows up as a missing or extra writeback at the next eviction of that set, or as a wrong `snp_supply` on the next snooped fill. The bench therefore follows each state-setting event with the store, snoop or eviction that exposes the state, and compares bus command counts, addresses and data against figures derived from the requirements.

// File: rtl/upd_coh_pkg.sv
// Shared types for the write-update coherence controller.
// Assumes: bus command codes are fixed by the bus and shared with the bench.
package upd_coh_pkg;

    typedef enum logic [2:0] {
        LS_INV = 3'd0,
        LS_VEX = 3'd1,
        LS_SCL = 3'd2,
        LS_SDY = 3'd3,
        LS_DTY = 3'd4
    } line_st_e;

    typedef enum logic [1:0] {
        BC_NONE = 2'd0,
        BC_FILL = 2'd1,
        BC_UPD  = 2'd2,
        BC_WBK  = 2'd3
    } bus_cmd_e;

    typedef enum logic [2:0] {
        F_IDLE = 3'd0,
        F_WBK  = 3'd1,
        F_FILL = 3'd2,
        F_BCST = 3'd3,
        F_DONE = 3'd4
    } fsm_st_e;

    // True for the states whose holder owns the data and must write it back.
    function automatic logic st_owned(line_st_e s);
        return (s == LS_SDY) || (s == LS_DTY);
    endfunction

endpackage

// File: rtl/upd_coh_store.sv
// Line store: state, tag and data for each direct-mapped set, a lookup port
// for the processor side, a snoop lookup, and the snoop-driven updates.
// Assumes: the bus never snoops a set in the same cycle that the local
// sequencer writes it; if that happens anyway, the snoop update wins.
module upd_coh_store
    import upd_coh_pkg::*;
#(
    parameter  int ADDR_W     = 8,
    parameter  int DATA_W     = 16,
    parameter  int LINE_WORDS = 4,
    parameter  int SETS       = 4,
    localparam int OFFW       = $clog2(LINE_WORDS),
    localparam int IDXW       = $clog2(SETS),
    localparam int TAGW       = ADDR_W - OFFW - IDXW,
    localparam int LW         = DATA_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [IDXW-1:0]   c_idx,
    output line_st_e          c_st,
    output logic [TAGW-1:0]   c_tag,
    output logic [LW-1:0]     c_line,
    input  logic              s_valid,
    input  logic [1:0]        s_cmd,
    input  logic [ADDR_W-1:0] s_addr,
    input  logic [DATA_W-1:0] s_wdata,
    output logic              s_hit,
    output line_st_e          s_st,
    output logic [LW-1:0]     s_line,
    input  logic              w_en,
    input  logic [IDXW-1:0]   w_idx,
    input  logic [TAGW-1:0]   w_tag,
    input  line_st_e          w_st,
    input  logic [LW-1:0]     w_line
);

    line_st_e          st_a  [SETS];
    logic [TAGW-1:0]   tag_a [SETS];
    logic [LW-1:0]     dat_a [SETS];

    logic [OFFW-1:0]   s_off;
    logic [IDXW-1:0]   s_idx;
    logic [TAGW-1:0]   s_tag;
    logic              s_apply;

    // Split the snooped address into offset, set and tag.
    assign s_off = s_addr[OFFW-1:0];
    assign s_idx = s_addr[OFFW +: IDXW];
    assign s_tag = s_addr[ADDR_W-1 -: TAGW];

    // Snoop lookup results.
    assign s_st    = st_a[s_idx];
    assign s_line  = dat_a[s_idx];
    assign s_hit   = (st_a[s_idx] != LS_INV) && (tag_a[s_idx] == s_tag);
    assign s_apply = s_valid && s_hit &&
                     ((s_cmd == BC_FILL) || (s_cmd == BC_UPD));

    // Processor-side lookup results.
    assign c_st   = st_a[c_idx];
    assign c_tag  = tag_a[c_idx];
    assign c_line = dat_a[c_idx];

    for (genvar g = 0; g < SETS; g++) begin : g_set
        line_st_e        st_r;
        logic [TAGW-1:0] tag_r;
        logic [LW-1:0]   dat_r;

        // Per-set register: the snoop update has priority over the local write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                st_r  <= LS_INV;
                tag_r <= '0;
                dat_r <= '0;
            end else if (s_apply && (s_idx == IDXW'(g))) begin
                if (s_cmd == BC_UPD) begin
                    st_r <= LS_SCL;
                    dat_r[int'(s_off)*DATA_W +: DATA_W] <= s_wdata;
                end else if (st_r == LS_VEX) begin
                    st_r <= LS_SCL;
                end else if (st_r == LS_DTY) begin
                    st_r <= LS_SDY;
                end
            end else if (w_en && (w_idx == IDXW'(g))) begin
                st_r  <= w_st;
                tag_r <= w_tag;
                dat_r <= w_line;
            end
        end

        assign st_a[g]  = st_r;
        assign tag_a[g] = tag_r;
        assign dat_a[g] = dat_r;
    end

endmodule

// File: rtl/upd_coh_fsm.sv
// Master sequencer: runs one processor request at a time through hit
// handling, writeback of an owned victim, line fill and word broadcast.
// It picks the next line state from the copy-present sample taken at each
// bus acknowledge.
// Assumes: cpu request fields stay stable until cpu_done; bus_ack is a
// single-cycle pulse that arrives only while bus_req is high.
module upd_coh_fsm
    import upd_coh_pkg::*;
#(
    parameter  int ADDR_W     = 8,
    parameter  int DATA_W     = 16,
    parameter  int LINE_WORDS = 4,
    parameter  int SETS       = 4,
    localparam int OFFW       = $clog2(LINE_WORDS),
    localparam int IDXW       = $clog2(SETS),
    localparam int TAGW       = ADDR_W - OFFW - IDXW,
    localparam int LW         = DATA_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    input  line_st_e          c_st,
    input  logic [TAGW-1:0]   c_tag,
    input  logic [LW-1:0]     c_line,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [LW-1:0]     bus_line_out,
    input  logic              bus_ack,
    input  logic [LW-1:0]     bus_line_in,
    input  logic              shd_in,
    output logic              w_en,
    output logic [IDXW-1:0]   w_idx,
    output logic [TAGW-1:0]   w_tag,
    output line_st_e          w_st,
    output logic [LW-1:0]     w_line
);

    fsm_st_e           fs_q, fs_d;
    logic [DATA_W-1:0] rdata_q, rdata_d;

    logic [OFFW-1:0]   r_off;
    logic [IDXW-1:0]   r_idx;
    logic [TAGW-1:0]   r_tag;
    logic              r_hit;
    logic [LW-1:0]     hit_merge;
    logic [LW-1:0]     fill_merge;

    // Request address split and hit test against the looked-up set.
    assign r_off = cpu_addr[OFFW-1:0];
    assign r_idx = cpu_addr[OFFW +: IDXW];
    assign r_tag = cpu_addr[ADDR_W-1 -: TAGW];
    assign r_hit = (c_st != LS_INV) && (c_tag == r_tag);

    // Store data merged into the cached line and into the incoming fill line.
    always_comb begin
        hit_merge  = c_line;
        fill_merge = bus_line_in;
        hit_merge[int'(r_off)*DATA_W +: DATA_W]  = cpu_wdata;
        fill_merge[int'(r_off)*DATA_W +: DATA_W] = cpu_wdata;
    end

    // Next-state, bus drive and store-write decisions.
    always_comb begin
        fs_d         = fs_q;
        rdata_d      = rdata_q;
        bus_req      = 1'b0;
        bus_cmd      = BC_NONE;
        bus_addr     = '0;
        bus_wdata    = '0;
        bus_line_out = '0;
        w_en         = 1'b0;
        w_idx        = r_idx;
        w_tag        = r_tag;
        w_st         = c_st;
        w_line       = c_line;
        unique case (fs_q)
            F_IDLE: begin
                if (cpu_req) begin
                    if (r_hit && !cpu_we) begin
                        rdata_d = c_line[int'(r_off)*DATA_W +: DATA_W];
                        fs_d    = F_DONE;
                    end else if (r_hit) begin
                        w_en   = 1'b1;
                        w_line = hit_merge;
                        if ((c_st == LS_VEX) || (c_st == LS_DTY)) begin
                            w_st = LS_DTY;
                            fs_d = F_DONE;
                        end else begin
                            fs_d = F_BCST;
                        end
                    end else if (st_owned(c_st)) begin
                        fs_d = F_WBK;
                    end else begin
                        fs_d = F_FILL;
                    end
                end
            end
            F_WBK: begin
                bus_req      = 1'b1;
                bus_cmd      = BC_WBK;
                bus_addr     = {c_tag, r_idx, {OFFW{1'b0}}};
                bus_line_out = c_line;
                if (bus_ack) fs_d = F_FILL;
            end
            F_FILL: begin
                bus_req  = 1'b1;
                bus_cmd  = BC_FILL;
                bus_addr = {r_tag, r_idx, {OFFW{1'b0}}};
                if (bus_ack) begin
                    w_en = 1'b1;
                    if (!cpu_we) begin
                        w_line  = bus_line_in;
                        w_st    = shd_in ? LS_SCL : LS_VEX;
                        rdata_d = bus_line_in[int'(r_off)*DATA_W +: DATA_W];
                        fs_d    = F_DONE;
                    end else if (shd_in) begin
                        w_line = fill_merge;
                        w_st   = LS_SCL;
                        fs_d   = F_BCST;
                    end else begin
                        w_line = fill_merge;
                        w_st   = LS_DTY;
                        fs_d   = F_DONE;
                    end
                end
            end
            F_BCST: begin
                bus_req   = 1'b1;
                bus_cmd   = BC_UPD;
                bus_addr  = cpu_addr;
                bus_wdata = cpu_wdata;
                if (bus_ack) begin
                    w_en = 1'b1;
                    w_st = shd_in ? LS_SDY : LS_DTY;
                    fs_d = F_DONE;
                end
            end
            F_DONE: fs_d = F_IDLE;
            default: fs_d = F_IDLE;
        endcase
    end

    // Sequencer state and load-result registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            fs_q    <= F_IDLE;
            rdata_q <= '0;
        end else begin
            fs_q    <= fs_d;
            rdata_q <= rdata_d;
        end
    end

    assign cpu_done  = (fs_q == F_DONE);
    assign cpu_rdata = rdata_q;

endmodule

// File: rtl/upd_coh_ctrl.sv
// Top of the write-update coherence controller for one cache. It ties the
// line store to the master sequencer and forms the snoop responses: the
// copy-present signal and the line supply from an owned copy.
// Assumes: snooped transactions come only from other caches and never
// overlap this cache's own bus transaction on the same set.
module upd_coh_ctrl
    import upd_coh_pkg::*;
#(
    parameter int ADDR_W     = 8,
    parameter int DATA_W     = 16,
    parameter int LINE_WORDS = 4,
    parameter int SETS       = 4,
    parameter int LINE_W     = DATA_W * LINE_WORDS
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cpu_req,
    input  logic              cpu_we,
    input  logic [ADDR_W-1:0] cpu_addr,
    input  logic [DATA_W-1:0] cpu_wdata,
    output logic              cpu_done,
    output logic [DATA_W-1:0] cpu_rdata,
    output logic              bus_req,
    output logic [1:0]        bus_cmd,
    output logic [ADDR_W-1:0] bus_addr,
    output logic [DATA_W-1:0] bus_wdata,
    output logic [LINE_W-1:0] bus_line_out,
    input  logic              bus_ack,
    input  logic [LINE_W-1:0] bus_line_in,
    input  logic              shd_in,
    input  logic              snp_valid,
    input  logic [1:0]        snp_cmd,
    input  logic [ADDR_W-1:0] snp_addr,
    input  logic [DATA_W-1:0] snp_wdata,
    output logic              shd_out,
    output logic              snp_supply,
    output logic [LINE_W-1:0] snp_line
);

    localparam int OFFW = $clog2(LINE_WORDS);
    localparam int IDXW = $clog2(SETS);
    localparam int TAGW = ADDR_W - OFFW - IDXW;

    line_st_e          c_st, s_st, w_st;
    logic [TAGW-1:0]   c_tag, w_tag;
    logic [LINE_W-1:0] c_line, w_line;
    logic [IDXW-1:0]   w_idx;
    logic              w_en, s_hit;

    upd_coh_store #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS)
    ) u_store (
        .clk     (clk),
        .rst_n   (rst_n),
        .c_idx   (cpu_addr[OFFW +: IDXW]),
        .c_st    (c_st),
        .c_tag   (c_tag),
        .c_line  (c_line),
        .s_valid (snp_valid),
        .s_cmd   (snp_cmd),
        .s_addr  (snp_addr),
        .s_wdata (snp_wdata),
        .s_hit   (s_hit),
        .s_st    (s_st),
        .s_line  (snp_line),
        .w_en    (w_en),
        .w_idx   (w_idx),
        .w_tag   (w_tag),
        .w_st    (w_st),
        .w_line  (w_line)
    );

    upd_coh_fsm #(
        .ADDR_W(ADDR_W), .DATA_W(DATA_W), .LINE_WORDS(LINE_WORDS), .SETS(SETS)
    ) u_fsm (
        .clk          (clk),
        .rst_n        (rst_n),
        .cpu_req      (cpu_req),
        .cpu_we       (cpu_we),
        .cpu_addr     (cpu_addr),
        .cpu_wdata    (cpu_wdata),
        .cpu_done     (cpu_done),
        .cpu_rdata    (cpu_rdata),
        .c_st         (c_st),
        .c_tag        (c_tag),
        .c_line       (c_line),
        .bus_req      (bus_req),
        .bus_cmd      (bus_cmd),
        .bus_addr     (bus_addr),
        .bus_wdata    (bus_wdata),
        .bus_line_out (bus_line_out),
        .bus_ack      (bus_ack),
        .bus_line_in  (bus_line_in),
        .shd_in       (shd_in),
        .w_en         (w_en),
        .w_idx        (w_idx),
        .w_tag        (w_tag),
        .w_st         (w_st),
        .w_line       (w_line)
    );

    // Snoop responses: presence for fills and updates, supply from an owned copy.
    assign shd_out    = snp_valid && s_hit &&
                        ((snp_cmd == BC_FILL) || (snp_cmd == BC_UPD));
    assign snp_supply = shd_out && (snp_cmd == BC_FILL) && st_owned(s_st);

endmodule

// File: rtl/upd_coh_ctrl_chk.sv
// Port-level protocol checker for upd_coh_ctrl, attached with bind.
// Assumes: synchronous active-low reset on rst_n.
module upd_coh_ctrl_chk #(
    parameter int ADDR_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cpu_done,
    input logic              bus_req,
    input logic [1:0]        bus_cmd,
    input logic [ADDR_W-1:0] bus_addr,
    input logic              bus_ack,
    input logic              snp_valid,
    input logic [1:0]        snp_cmd,
    input logic              shd_out,
    input logic              snp_supply
);

    a_r12_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |=> !cpu_done);

    a_r11_cmd_legal: assert property (@(posedge clk) disable iff (!rst_n)
        bus_req |-> (bus_cmd != 2'd0));

    a_r11_idle_cmd: assert property (@(posedge clk) disable iff (!rst_n)
        !bus_req |-> (bus_cmd == 2'd0));

    a_r5_req_held: assert property (@(posedge clk) disable iff (!rst_n)
        (bus_req && !bus_ack) |=> (bus_req && $stable(bus_cmd) && $stable(bus_addr)));

    a_r8_shd_needs_snoop: assert property (@(posedge clk) disable iff (!rst_n)
        shd_out |-> snp_valid);

    a_r9_supply_on_fill: assert property (@(posedge clk) disable iff (!rst_n)
        snp_supply |-> (shd_out && (snp_cmd == 2'd1)));

    a_r10_quiet_on_wbk: assert property (@(posedge clk) disable iff (!rst_n)
        (snp_valid && (snp_cmd == 2'd3)) |-> !shd_out);

    a_r12_done_no_bus: assert property (@(posedge clk) disable iff (!rst_n)
        cpu_done |-> !bus_req);

endmodule

bind upd_coh_ctrl upd_coh_ctrl_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cpu_done   (cpu_done),
    .bus_req    (bus_req),
    .bus_cmd    (bus_cmd),
    .bus_addr   (bus_addr),
    .bus_ack    (bus_ack),
    .snp_valid  (snp_valid),
    .snp_cmd    (snp_cmd),
    .shd_out    (shd_out),
    .snp_supply (snp_supply)
);

// File: tb/upd_coh_ctrl_bench.sv
// Bench for upd_coh_ctrl: plays the memory, the bus and the other caches.
// It sweeps every set and every combination of copy-present answers for
// fills and broadcasts.
`timescale 1ns/1ps
module upd_coh_ctrl_bench;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cpu_req = 1'b0, cpu_we = 1'b0;
    logic [7:0]  cpu_addr = '0;
    logic [15:0] cpu_wdata = '0;
    logic        cpu_done;
    logic [15:0] cpu_rdata;
    logic        bus_req;
    logic [1:0]  bus_cmd;
    logic [7:0]  bus_addr;
    logic [15:0] bus_wdata;
    logic [63:0] bus_line_out;
    logic        bus_ack = 1'b0;
    logic [63:0] bus_line_in = '0;
    logic        shd_in = 1'b0;
    logic        snp_valid = 1'b0;
    logic [1:0]  snp_cmd = '0;
    logic [7:0]  snp_addr = '0;
    logic [15:0] snp_wdata = '0;
    logic        shd_out, snp_supply;
    logic [63:0] snp_line;

    int checks = 0, errors = 0;
    logic [15:0] mem [256];
    logic        shd_rd = 1'b0, shd_wr = 1'b0;
    int          n_fill, n_upd, n_wbk;
    logic [7:0]  fill_a, upd_a, wbk_a;
    logic [15:0] upd_d;
    logic [63:0] wbk_l;

    always #4 clk = ~clk;

    upd_coh_ctrl u_upd_coh_ctrl (
        .clk(clk), .rst_n(rst_n), .cpu_req(cpu_req), .cpu_we(cpu_we),
        .cpu_addr(cpu_addr), .cpu_wdata(cpu_wdata), .cpu_done(cpu_done),
        .cpu_rdata(cpu_rdata), .bus_req(bus_req), .bus_cmd(bus_cmd),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_line_out(bus_line_out),
        .bus_ack(bus_ack), .bus_line_in(bus_line_in), .shd_in(shd_in),
        .snp_valid(snp_valid), .snp_cmd(snp_cmd), .snp_addr(snp_addr),
        .snp_wdata(snp_wdata), .shd_out(shd_out), .snp_supply(snp_supply),
        .snp_line(snp_line)
    );

    function automatic logic [63:0] mem_line(logic [7:0] a);
        logic [63:0] l;
        for (int i = 0; i < 4; i++) l[i*16 +: 16] = mem[{a[7:2], 2'(i)}];
        return l;
    endfunction

    // Bus responder: acknowledge each request one negedge after seeing it.
    always @(negedge clk) begin
        if (bus_ack) begin
            bus_ack <= 1'b0;
            shd_in  <= 1'b0;
        end else if (rst_n && bus_req) begin
            if (bus_cmd == 2'd1) begin
                n_fill++; fill_a = bus_addr;
                bus_line_in <= mem_line(bus_addr);
                shd_in <= shd_rd;
            end else if (bus_cmd == 2'd2) begin
                n_upd++; upd_a = bus_addr; upd_d = bus_wdata;
                shd_in <= shd_wr;
            end else begin
                n_wbk++; wbk_a = bus_addr; wbk_l = bus_line_out;
                for (int i = 0; i < 4; i++) mem[{bus_addr[7:2], 2'(i)}] = bus_line_out[i*16 +: 16];
                shd_in <= 1'b0;
            end
            bus_ack <= 1'b1;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    task automatic clr();
        n_fill = 0; n_upd = 0; n_wbk = 0;
    endtask

    task automatic cpu_op(input logic we, input logic [7:0] a, input logic [15:0] d,
                          output logic [15:0] rd);
        @(negedge clk);
        cpu_req = 1'b1; cpu_we = we; cpu_addr = a; cpu_wdata = d;
        forever begin
            @(negedge clk);
            if (cpu_done) break;
        end
        rd = cpu_rdata;
        cpu_req = 1'b0;
        @(negedge clk);
        chk(!cpu_done, "R12 done pulse", int'(cpu_done), 0);
    endtask

    task automatic snoop(input logic [1:0] c, input logic [7:0] a, input logic [15:0] d,
                         input logic e_shd, input logic e_sup, input logic [15:0] e_word,
                         input string req);
        @(negedge clk);
        snp_valid = 1'b1; snp_cmd = c; snp_addr = a; snp_wdata = d;
        #1;
        chk(shd_out == e_shd, {req, " shd_out"}, int'(shd_out), int'(e_shd));
        chk(snp_supply == e_sup, {req, " supply"}, int'(snp_supply), int'(e_sup));
        if (e_sup)
            chk(snp_line[a[1:0]*16 +: 16] == e_word, {req, " line"},
                int'(snp_line[a[1:0]*16 +: 16]), int'(e_word));
        @(negedge clk);
        snp_valid = 1'b0;
    endtask

    task automatic finish_run();
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    endtask

    initial begin
        repeat (60000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual hung expected done");
        finish_run();
    end

    initial begin
        logic [15:0] rd;
        for (int a = 0; a < 256; a++) mem[a] = 16'(a * 263 + 16'h3C00);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(!cpu_done && !bus_req && !shd_out, "R1 idle outputs",
            int'({cpu_done, bus_req, shd_out}), 0);
        for (int a = 0; a < 256; a += 4)
            snoop(2'd1, 8'(a), 16'h0, 1'b0, 1'b0, 16'h0, "R1 empty");

        for (int idx = 0; idx < 4; idx++) begin
            for (int s = 0; s < 2; s++) begin
                for (int b = 0; b < 2; b++) begin
                    logic [3:0]  ta, tb, tc;
                    logic [1:0]  w;
                    logic [7:0]  aa, ab, ac;
                    logic [15:0] d1, d2, d3, d4, e;
                    ta = 4'(s*2 + b); tb = ta + 4'd4; tc = ta + 4'd8;
                    w  = 2'(idx + 2*s + b);
                    aa = {ta, 2'(idx), w}; ab = {tb, 2'(idx), ~w}; ac = {tc, 2'(idx), w};
                    d1 = 16'(16'hA000 + idx*64 + s*16 + b*4);
                    d2 = d1 + 16'd1; d3 = d1 + 16'd2; d4 = d1 + 16'd3;

                    // R2 load miss: clean victim, fill state chosen by shd
                    clr(); shd_rd = 1'(s); e = mem[aa];
                    cpu_op(1'b0, aa, 16'h0, rd);
                    chk(rd == e, "R2 fill data", int'(rd), int'(e));
                    chk(n_fill == 1 && fill_a == {aa[7:2], 2'b00}, "R2 fill cmd",
                        int'(fill_a), int'({aa[7:2], 2'b00}));
                    chk(n_wbk == 0, "R7 clean victim no writeback", n_wbk, 0);

                    // R3 load hit
                    clr(); cpu_op(1'b0, aa, 16'h0, rd);
                    chk(rd == e && n_fill == 0, "R3 hit", int'(rd), int'(e));

                    // R4/R5 store hit from VE or SC
                    clr(); shd_wr = 1'(b);
                    cpu_op(1'b1, aa, d1, rd);
                    chk(n_upd == s, "R4 R5 first store bus", n_upd, s);
                    if (s == 1) chk(upd_a == aa && upd_d == d1, "R5 update word",
                                    int'(upd_d), int'(d1));

                    // second store: only Shared-Dirty broadcasts again
                    clr(); cpu_op(1'b1, aa, d2, rd);
                    chk(n_upd == s*b, "R4 R5 second store bus", n_upd, s*b);

                    // R8 R9 snooped fill of owned line: supply, goes Shared-Dirty
                    snoop(2'd1, aa, 16'h0, 1'b1, 1'b1, d2, "R9 owned");
                    snoop(2'd1, {~ta, 2'(idx), w}, 16'h0, 1'b0, 1'b0, 16'h0, "R8 other tag");
                    snoop(2'd3, aa, 16'h0, 1'b0, 1'b0, 16'h0, "R10 writeback snoop");

                    // now Shared-Dirty: store must broadcast
                    clr(); cpu_op(1'b1, aa, d3, rd);
                    chk(n_upd == 1 && upd_d == d3, "R9 D to SD", n_upd, 1);

                    if (b == 1) begin
                        // R10 snooped update patches copy and drops ownership
                        snoop(2'd2, {aa[7:2], ~w}, d4, 1'b1, 1'b0, 16'h0, "R10 update");
                        clr(); cpu_op(1'b0, {aa[7:2], ~w}, 16'h0, rd);
                        chk(rd == d4 && n_fill == 0, "R10 patched word", int'(rd), int'(d4));
                        clr(); shd_rd = 1'(s); e = mem[ab];
                        cpu_op(1'b0, ab, 16'h0, rd);
                        chk(n_wbk == 0 && n_fill == 1, "R10 R7 SC victim", n_wbk, 0);
                        chk(rd == e, "R2 fill data B", int'(rd), int'(e));
                    end else begin
                        clr(); shd_rd = 1'(s); e = mem[ab];
                        cpu_op(1'b0, ab, 16'h0, rd);
                        chk(n_wbk == 1 && wbk_a == {aa[7:2], 2'b00}, "R7 writeback addr",
                            int'(wbk_a), int'({aa[7:2], 2'b00}));
                        chk(wbk_l[w*16 +: 16] == d3, "R7 writeback data",
                            int'(wbk_l[w*16 +: 16]), int'(d3));
                        chk(n_fill == 1 && rd == e, "R7 fill after writeback", int'(rd), int'(e));
                    end

                    // R6 store miss
                    clr(); shd_rd = 1'(s); shd_wr = 1'(b);
                    cpu_op(1'b1, ac, d4, rd);
                    chk(n_fill == 1 && n_wbk == 0, "R6 fill", n_fill, 1);
                    chk(n_upd == s, "R6 broadcast iff shared", n_upd, s);
                    if (s == 1) chk(upd_a == ac && upd_d == d4, "R6 update word",
                                    int'(upd_d), int'(d4));
                    clr(); cpu_op(1'b0, ac, 16'h0, rd);
                    chk(rd == d4 && n_fill == 0, "R6 merged word", int'(rd), int'(d4));
                    clr(); e = mem[ab];
                    cpu_op(1'b0, ab, 16'h0, rd);
                    chk(n_wbk == 1 && wbk_l[w*16 +: 16] == d4, "R7 owned after miss",
                        int'(wbk_l[w*16 +: 16]), int'(d4));

                    // R9 snooped fill of clean line: no supply, VE becomes SC
                    snoop(2'd1, ab, 16'h0, 1'b1, 1'b0, 16'h0, "R9 clean");
                    clr(); shd_wr = 1'b0;
                    cpu_op(1'b1, ab, d1, rd);
                    chk(n_upd == 1, "R9 clean to SC then broadcast", n_upd, 1);
                    // R10 update leaves a Dirty copy Shared-Clean (checked by next fill)
                    snoop(2'd2, ab, d2, 1'b1, 1'b0, 16'h0, "R10 update on dirty");
                end
            end
        end
        finish_run();
    end

endmodule